// File: doc/BRIEF.md
# Single-Bit NAND Sector ECC Corrector

This block handles the 24-bit single-error-correcting check code that protects one 512-byte NAND sector. On the write path it takes the raw 32-bit parity word produced by an upstream parity accumulator and turns it into the three code bytes that are stored in the spare area. The code is inverted before storage, so a freshly erased page (all ones in data and spare) checks clean.

On the read path it takes the code that was stored with the sector and the code computed from the data just read. It classifies the pair as clean, a correctable data-bit error, damage to the stored code alone, or uncorrectable. For a correctable error it names the byte and the bit to flip. It also fetches that byte through a lookup port with a fixed read latency, so it suits a block RAM sector buffer, and returns the repaired byte with the result. Checks are fully pipelined and may arrive on every cycle.

Top module: `necc_corrector`

## Requirements
- R1: One cycle after `enc_valid_i`, `enc_valid_o` pulses and `enc_code_o` equals the bitwise inverse of {parity[27:16], parity[11:0]}; code byte k sits at `enc_code_o[8k+7:8k]`, byte 0 (bits 7:0) being the first byte stored.
- R2: Parity bits 31:28 and 15:12 have no effect on the code, and a parity word whose used bits are all zero encodes to 0xFFFFFF, the code an erased page holds.
- R3: With difference d = stored XOR computed, d = 0 reports status 0 (clean) with byte index, bit index and output byte all zero.
- R4: When d[23:12] XOR d[11:0] = 0xFFF and d[23:15] is below the sector size, status is 1 (corrected), `chk_byte_idx_o` = d[23:15] and `chk_bit_idx_o` = d[14:12].
- R5: A correctable pattern whose byte index d[23:15] is not below `SECTOR_BYTES` reports status 3 and issues no fetch.
- R6: A difference with exactly one bit set reports status 2 (code-only error), no fetch, and byte index, bit index and output byte all zero.
- R7: Every other nonzero difference reports status 3 (uncorrectable) with index fields and output byte zero.
- R8: For status 1, `fetch_req_o` pulses with `fetch_idx_o` = byte index one cycle after the check is taken; the byte on `fetch_byte_i` RD_LAT cycles later is returned on `chk_byte_o` with exactly the named bit inverted.
- R9: One check may be taken per cycle; `chk_valid_o` pulses once per check, RD_LAT+2 cycles after it is taken, results in input order.
- R10: Reset clears `enc_valid_o`, `chk_valid_o` and `fetch_req_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| enc_valid_i | input | 1 | Parity word valid |
| enc_parity_i | input | 32 | Raw parity word from the accumulator |
| enc_valid_o | output | 1 | Code valid strobe |
| enc_code_o | output | 24 | Code to store, byte 0 in bits 7:0 |
| chk_valid_i | input | 1 | Check request valid |
| chk_stored_i | input | 24 | Code read back from the spare area |
| chk_computed_i | input | 24 | Code computed over the data read |
| fetch_req_o | output | 1 | Byte lookup request |
| fetch_idx_o | output | 9 | Byte index to look up |
| fetch_byte_i | input | 8 | Looked-up byte, RD_LAT cycles after the request |
| chk_valid_o | output | 1 | Result valid strobe |
| chk_status_o | output | 2 | 0 clean, 1 corrected, 2 code-only, 3 uncorrectable |
| chk_byte_idx_o | output | 9 | Byte to repair |
| chk_bit_idx_o | output | 3 | Bit within that byte |
| chk_byte_o | output | 8 | Repaired byte |

## Verification
The bench pushes correctable patterns at byte 0 bit 0 and byte 511 bit 7. A design that swapped the index fields or mis-sliced the difference would name the wrong byte and return a wrong repaired byte. Single-bit differences at bits 0, 12 and 23 are aimed at a classifier that tests for one set bit before the complementary-halves rule, or that fetches and flips data for code damage. A second instance with a 300-byte sector probes the bound at 299, 300 and 511, which catches an off-by-one or missing range check. Back-to-back mixed bursts and all-ones, two-bit and ignored-parity-bit patterns expose pipeline misalignment between the fetched byte and its result, and encoders that take the wrong half or skip the inversion.

// File: rtl/necc_pkg.sv
package necc_pkg;

  typedef enum logic [1:0] {
    ST_CLEAN = 2'd0,
    ST_FIXED = 2'd1,
    ST_CODE  = 2'd2,
    ST_FATAL = 2'd3
  } necc_status_e;

  localparam int BIT_W = 3;

endpackage

// File: rtl/necc_encoder.sv
module necc_encoder #(
  parameter int PAR_W  = 32,
  parameter int HALF_W = 12,
  parameter int HI_LSB = 16
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  valid_i,
  input  logic [PAR_W-1:0]      parity_i,
  output logic                  valid_o,
  output logic [2*HALF_W-1:0]   code_o
);

  localparam int CODE_W = 2 * HALF_W;

  logic [CODE_W-1:0] packed_code;

  // Upper half of the parity word lands above the lower half, then the
  // whole code is inverted so an erased page reads back as all ones.
  assign packed_code = ~{parity_i[HI_LSB +: HALF_W], parity_i[0 +: HALF_W]};

  always_ff @(posedge clk) begin
    if (rst) begin
      valid_o <= 1'b0;
      code_o  <= '0;
    end else begin
      valid_o <= valid_i;
      if (valid_i) begin
        code_o <= packed_code;
      end
    end
  end

endmodule

// File: rtl/necc_classify.sv
module necc_classify
  import necc_pkg::*;
#(
  parameter int HALF_W       = 12,
  parameter int SECTOR_BYTES = 512
) (
  input  logic [2*HALF_W-1:0]      stored_i,
  input  logic [2*HALF_W-1:0]      computed_i,
  output necc_status_e             status_o,
  output logic [HALF_W-BIT_W-1:0]  idx_o,
  output logic [BIT_W-1:0]         bit_o
);

  localparam int CODE_W = 2 * HALF_W;
  localparam int IDX_W  = HALF_W - BIT_W;

  logic [CODE_W-1:0] diff;
  logic [HALF_W-1:0] diff_hi;
  logic [HALF_W-1:0] diff_lo;
  logic              is_zero;
  logic              pair_ok;
  logic              lone_bit;
  logic              in_range;
  logic [IDX_W-1:0]  cand_idx;
  logic [BIT_W-1:0]  cand_bit;

  assign diff     = stored_i ^ computed_i;
  assign diff_hi  = diff[CODE_W-1:HALF_W];
  assign diff_lo  = diff[HALF_W-1:0];
  assign is_zero  = (diff == '0);
  assign pair_ok  = ((diff_hi ^ diff_lo) == '1);
  assign lone_bit = ((diff & (diff - 1'b1)) == '0);
  assign cand_idx = diff_hi[HALF_W-1:BIT_W];
  assign cand_bit = diff_hi[BIT_W-1:0];

  // The range test disappears when the index field cannot exceed the sector.
  generate
    if (SECTOR_BYTES >= (1 << IDX_W)) begin : g_full_range
      assign in_range = 1'b1;
    end else begin : g_bounded
      assign in_range = (cand_idx < IDX_W'(SECTOR_BYTES));
    end
  endgenerate

  always_comb begin
    status_o = ST_FATAL;
    idx_o    = '0;
    bit_o    = '0;
    if (is_zero) begin
      status_o = ST_CLEAN;
    end else if (pair_ok) begin
      if (in_range) begin
        status_o = ST_FIXED;
        idx_o    = cand_idx;
        bit_o    = cand_bit;
      end
    end else if (lone_bit) begin
      status_o = ST_CODE;
    end
  end

endmodule

// File: rtl/necc_pipe.sv
module necc_pipe #(
  parameter int W     = 8,
  parameter int DEPTH = 1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);

  generate
    if (DEPTH == 0) begin : g_wire
      assign q_o = d_i;
    end else begin : g_regs
      logic [W-1:0] stage [DEPTH];
      for (genvar s = 0; s < DEPTH; s++) begin : g_stage
        always_ff @(posedge clk) begin
          if (rst) begin
            stage[s] <= '0;
          end else if (s == 0) begin
            stage[s] <= d_i;
          end else begin
            stage[s] <= stage[(s == 0) ? 0 : s-1];
          end
        end
      end
      assign q_o = stage[DEPTH-1];
    end
  endgenerate

endmodule

// File: rtl/necc_flip.sv
module necc_flip
  import necc_pkg::*;
(
  input  logic [7:0]       byte_i,
  input  logic [BIT_W-1:0] bit_i,
  input  logic             en_i,
  output logic [7:0]       byte_o
);

  logic [7:0] mask;

  generate
    for (genvar b = 0; b < 8; b++) begin : g_mask
      assign mask[b] = (bit_i == BIT_W'(b));
    end
  endgenerate

  assign byte_o = en_i ? (byte_i ^ mask) : 8'h00;

endmodule

// File: rtl/necc_corrector.sv
module necc_corrector
  import necc_pkg::*;
#(
  parameter int PAR_W        = 32,
  parameter int HALF_W       = 12,
  parameter int HI_LSB       = 16,
  parameter int SECTOR_BYTES = 512,
  parameter int RD_LAT       = 1
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     enc_valid_i,
  input  logic [PAR_W-1:0]         enc_parity_i,
  output logic                     enc_valid_o,
  output logic [2*HALF_W-1:0]      enc_code_o,
  input  logic                     chk_valid_i,
  input  logic [2*HALF_W-1:0]      chk_stored_i,
  input  logic [2*HALF_W-1:0]      chk_computed_i,
  output logic                     fetch_req_o,
  output logic [HALF_W-BIT_W-1:0]  fetch_idx_o,
  input  logic [7:0]               fetch_byte_i,
  output logic                     chk_valid_o,
  output logic [1:0]               chk_status_o,
  output logic [HALF_W-BIT_W-1:0]  chk_byte_idx_o,
  output logic [BIT_W-1:0]         chk_bit_idx_o,
  output logic [7:0]               chk_byte_o
);

  localparam int IDX_W  = HALF_W - BIT_W;
  localparam int META_W = 1 + 2 + IDX_W + BIT_W;

  // Write path
  necc_encoder #(
    .PAR_W  (PAR_W),
    .HALF_W (HALF_W),
    .HI_LSB (HI_LSB)
  ) enc_u (
    .clk      (clk),
    .rst      (rst),
    .valid_i  (enc_valid_i),
    .parity_i (enc_parity_i),
    .valid_o  (enc_valid_o),
    .code_o   (enc_code_o)
  );

  // Read path, stage 1: classify and register
  necc_status_e      cls_status;
  logic [IDX_W-1:0]  cls_idx;
  logic [BIT_W-1:0]  cls_bit;

  necc_classify #(
    .HALF_W       (HALF_W),
    .SECTOR_BYTES (SECTOR_BYTES)
  ) cls_u (
    .stored_i   (chk_stored_i),
    .computed_i (chk_computed_i),
    .status_o   (cls_status),
    .idx_o      (cls_idx),
    .bit_o      (cls_bit)
  );

  logic              s1_valid;
  necc_status_e      s1_status;
  logic [IDX_W-1:0]  s1_idx;
  logic [BIT_W-1:0]  s1_bit;

  always_ff @(posedge clk) begin
    if (rst) begin
      s1_valid  <= 1'b0;
      s1_status <= ST_CLEAN;
      s1_idx    <= '0;
      s1_bit    <= '0;
    end else begin
      s1_valid <= chk_valid_i;
      if (chk_valid_i) begin
        s1_status <= cls_status;
        s1_idx    <= cls_idx;
        s1_bit    <= cls_bit;
      end
    end
  end

  assign fetch_req_o = s1_valid && (s1_status == ST_FIXED);
  assign fetch_idx_o = s1_idx;

  // Hold the stage 1 result while the byte lookup completes
  logic [META_W-1:0] meta_d;
  logic [META_W-1:0] meta_q;

  assign meta_d = {s1_valid, 2'(s1_status), s1_idx, s1_bit};

  necc_pipe #(
    .W     (META_W),
    .DEPTH (RD_LAT)
  ) wait_u (
    .clk (clk),
    .rst (rst),
    .d_i (meta_d),
    .q_o (meta_q)
  );

  logic              w_valid;
  necc_status_e      w_status;
  logic [IDX_W-1:0]  w_idx;
  logic [BIT_W-1:0]  w_bit;

  assign w_valid  = meta_q[META_W-1];
  assign w_status = necc_status_e'(meta_q[META_W-2 -: 2]);
  assign w_idx    = meta_q[BIT_W +: IDX_W];
  assign w_bit    = meta_q[BIT_W-1:0];

  // Stage 2: repair the fetched byte and register the result
  logic [7:0] fixed_byte;

  necc_flip flip_u (
    .byte_i (fetch_byte_i),
    .bit_i  (w_bit),
    .en_i   (w_status == ST_FIXED),
    .byte_o (fixed_byte)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      chk_valid_o    <= 1'b0;
      chk_status_o   <= 2'(ST_CLEAN);
      chk_byte_idx_o <= '0;
      chk_bit_idx_o  <= '0;
      chk_byte_o     <= '0;
    end else begin
      chk_valid_o <= w_valid;
      if (w_valid) begin
        chk_status_o   <= 2'(w_status);
        chk_byte_idx_o <= w_idx;
        chk_bit_idx_o  <= w_bit;
        chk_byte_o     <= fixed_byte;
      end
    end
  end

endmodule

// File: rtl/necc_corrector_chk.sv
module necc_corrector_chk
  import necc_pkg::*;
#(
  parameter int PAR_W        = 32,
  parameter int HALF_W       = 12,
  parameter int HI_LSB       = 16,
  parameter int SECTOR_BYTES = 512,
  parameter int RD_LAT       = 1
) (
  input logic                     clk,
  input logic                     rst,
  input logic                     enc_valid_i,
  input logic [PAR_W-1:0]         enc_parity_i,
  input logic                     enc_valid_o,
  input logic [2*HALF_W-1:0]      enc_code_o,
  input logic                     chk_valid_i,
  input logic [2*HALF_W-1:0]      chk_stored_i,
  input logic [2*HALF_W-1:0]      chk_computed_i,
  input logic                     s1_valid,
  input necc_status_e             s1_status,
  input logic                     fetch_req_o,
  input logic [HALF_W-BIT_W-1:0]  fetch_idx_o,
  input logic [7:0]               fetch_byte_i,
  input logic                     chk_valid_o,
  input logic [1:0]               chk_status_o,
  input logic [HALF_W-BIT_W-1:0]  chk_byte_idx_o,
  input logic [BIT_W-1:0]         chk_bit_idx_o,
  input logic [7:0]               chk_byte_o
);

  int inflight;

  always_ff @(posedge clk) begin
    if (rst) begin
      inflight <= 0;
    end else begin
      inflight <= inflight + (chk_valid_i ? 1 : 0) - (chk_valid_o ? 1 : 0);
    end
  end

  assert_enc_map_R1: assert property (@(posedge clk) disable iff (rst)
    enc_valid_i |=> enc_valid_o &&
      (enc_code_o == ~{$past(enc_parity_i[HI_LSB +: HALF_W]), $past(enc_parity_i[HALF_W-1:0])}));

  assert_clean_R3: assert property (@(posedge clk) disable iff (rst)
    chk_valid_i |=> s1_valid &&
      ((s1_status == ST_CLEAN) == ($past(chk_stored_i) == $past(chk_computed_i))));

  assert_in_bound_R5: assert property (@(posedge clk) disable iff (rst)
    fetch_req_o |-> (int'(fetch_idx_o) < SECTOR_BYTES));

  assert_code_only_R6: assert property (@(posedge clk) disable iff (rst)
    (chk_valid_o && chk_status_o == 2'd2) |->
      (chk_byte_o == 8'h00 && chk_byte_idx_o == '0 && chk_bit_idx_o == '0));

  assert_flip_R8: assert property (@(posedge clk) disable iff (rst)
    (chk_valid_o && chk_status_o == 2'd1) |->
      ((chk_byte_o ^ $past(fetch_byte_i)) == (8'd1 << chk_bit_idx_o)));

  assert_order_R9: assert property (@(posedge clk) disable iff (rst)
    chk_valid_o |-> (inflight > 0));

  assert_depth_R9: assert property (@(posedge clk) disable iff (rst)
    inflight <= RD_LAT + 2);

  assert_reset_R10: assert property (@(posedge clk)
    rst |=> (!enc_valid_o && !chk_valid_o && !fetch_req_o));

endmodule

bind necc_corrector necc_corrector_chk #(
  .PAR_W        (PAR_W),
  .HALF_W       (HALF_W),
  .HI_LSB       (HI_LSB),
  .SECTOR_BYTES (SECTOR_BYTES),
  .RD_LAT       (RD_LAT)
) chk_i (.*);

// File: tb/necc_corrector_tb.sv
module necc_corrector_tb_top;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2.5 clk = ~clk;

  // main instance, 512-byte sector
  logic        enc_valid_i = 1'b0;
  logic [31:0] enc_parity_i = '0;
  logic        enc_valid_o;
  logic [23:0] enc_code_o;
  logic        chk_valid_i = 1'b0;
  logic [23:0] chk_stored_i = '0;
  logic [23:0] chk_computed_i = '0;
  logic        fetch_req_o;
  logic [8:0]  fetch_idx_o;
  logic [7:0]  fetch_byte_i;
  logic        chk_valid_o;
  logic [1:0]  chk_status_o;
  logic [8:0]  chk_byte_idx_o;
  logic [2:0]  chk_bit_idx_o;
  logic [7:0]  chk_byte_o;

  necc_corrector dut_i (
    .clk, .rst, .enc_valid_i, .enc_parity_i, .enc_valid_o, .enc_code_o,
    .chk_valid_i, .chk_stored_i, .chk_computed_i, .fetch_req_o, .fetch_idx_o,
    .fetch_byte_i, .chk_valid_o, .chk_status_o, .chk_byte_idx_o,
    .chk_bit_idx_o, .chk_byte_o
  );

  // bounded instance, 300-byte sector
  logic        sm_valid_i = 1'b0;
  logic [23:0] sm_stored_i = '0;
  logic [23:0] sm_computed_i = '0;
  logic        sm_enc_valid_o;
  logic [23:0] sm_enc_code_o;
  logic        sm_fetch_req_o;
  logic [8:0]  sm_fetch_idx_o;
  logic [7:0]  sm_fetch_byte_i;
  logic        sm_valid_o;
  logic [1:0]  sm_status_o;
  logic [8:0]  sm_idx_o;
  logic [2:0]  sm_bit_o;
  logic [7:0]  sm_byte_o;

  necc_corrector #(.SECTOR_BYTES(300)) dut_small_i (
    .clk, .rst, .enc_valid_i(1'b0), .enc_parity_i(32'h0),
    .enc_valid_o(sm_enc_valid_o), .enc_code_o(sm_enc_code_o),
    .chk_valid_i(sm_valid_i), .chk_stored_i(sm_stored_i),
    .chk_computed_i(sm_computed_i), .fetch_req_o(sm_fetch_req_o),
    .fetch_idx_o(sm_fetch_idx_o), .fetch_byte_i(sm_fetch_byte_i),
    .chk_valid_o(sm_valid_o), .chk_status_o(sm_status_o),
    .chk_byte_idx_o(sm_idx_o), .chk_bit_idx_o(sm_bit_o), .chk_byte_o(sm_byte_o)
  );

  // sector buffer contents, read with one cycle of latency
  function automatic logic [7:0] sector_byte(input logic [8:0] a);
    return 8'((int'(a) * 37 + 11) ^ (int'(a) >> 3));
  endfunction

  always @(posedge clk) begin
    fetch_byte_i    <= sector_byte(fetch_idx_o);
    sm_fetch_byte_i <= sector_byte(sm_fetch_idx_o);
  end

  int n_vec = 0;
  int n_bad = 0;

  // scoreboard queues
  logic [1:0] q_status [$];
  logic [8:0] q_idx    [$];
  logic [2:0] q_bit    [$];
  logic [7:0] q_byte   [$];
  string      q_tag    [$];

  // independent model of the classification rules
  task automatic model(input logic [23:0] st, input logic [23:0] cp, input int sector,
                       output logic [1:0] s, output logic [8:0] idx,
                       output logic [2:0] b, output logic [7:0] by);
    logic [23:0] d;
    int ones;
    d = st ^ cp;
    s = 2'd3; idx = '0; b = '0; by = '0;
    ones = 0;
    for (int i = 0; i < 24; i++) ones += int'(d[i]);
    if (ones == 0) begin
      s = 2'd0;
    end else if (d[23:12] == ~d[11:0]) begin
      if (int'(d[23:15]) < sector) begin
        s = 2'd1; idx = d[23:15]; b = d[14:12];
        by = sector_byte(idx) ^ (8'd1 << b);
      end
    end else if (ones == 1) begin
      s = 2'd2;
    end
  endtask

  function automatic logic [23:0] err_pattern(input int byte_n, input int bit_n);
    logic [11:0] hi;
    hi = {9'(byte_n), 3'(bit_n)};
    return {hi, ~hi};
  endfunction

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  // driver: one check per call, valid held across consecutive calls
  task automatic push(input logic [23:0] st, input logic [23:0] cp, input string tag);
    logic [1:0] s; logic [8:0] idx; logic [2:0] b; logic [7:0] by;
    model(st, cp, 512, s, idx, b, by);
    q_status.push_back(s); q_idx.push_back(idx); q_bit.push_back(b);
    q_byte.push_back(by); q_tag.push_back(tag);
    chk_valid_i    = 1'b1;
    chk_stored_i   = st;
    chk_computed_i = cp;
    @(negedge clk);
  endtask

  task automatic idle(input int n);
    chk_valid_i = 1'b0;
    repeat (n) @(negedge clk);
  endtask

  task automatic drain;
    chk_valid_i = 1'b0;
    for (int i = 0; i < 20 && q_tag.size() != 0; i++) @(negedge clk);
    check(q_tag.size() == 0, "R9", "results missing", 32'(q_tag.size()), 32'd0);
  endtask

  // monitor: pops and compares as results appear
  task automatic monitor;
    forever begin
      @(negedge clk);
      if (!rst && chk_valid_o) begin
        if (q_tag.size() == 0) begin
          check(1'b0, "R9", "unexpected result", 32'(chk_status_o), 32'hx);
        end else begin
          logic [1:0] es; logic [8:0] ei; logic [2:0] eb; logic [7:0] ey; string t;
          es = q_status.pop_front(); ei = q_idx.pop_front(); eb = q_bit.pop_front();
          ey = q_byte.pop_front(); t = q_tag.pop_front();
          check({chk_status_o, chk_byte_idx_o, chk_bit_idx_o, chk_byte_o} == {es, ei, eb, ey},
                t, "status/idx/bit/byte",
                32'({chk_status_o, chk_byte_idx_o, chk_bit_idx_o, chk_byte_o}),
                32'({es, ei, eb, ey}));
        end
      end
    end
  endtask

  task automatic enc_case(input logic [31:0] p, input logic [23:0] exp, input string tag);
    enc_valid_i  = 1'b1;
    enc_parity_i = p;
    @(negedge clk);
    enc_valid_i = 1'b0;
    check(enc_valid_o && enc_code_o == exp, tag, "encoded code",
          32'({enc_valid_o, enc_code_o}), 32'({1'b1, exp}));
    check(enc_code_o[7:0] == exp[7:0], tag, "first code byte",
          32'(enc_code_o[7:0]), 32'(exp[7:0]));
  endtask

  task automatic small_case(input logic [23:0] d, input string tag);
    logic [1:0] s; logic [8:0] idx; logic [2:0] b; logic [7:0] by;
    bit saw_fetch;
    model(24'h0, d, 300, s, idx, b, by);
    sm_valid_i = 1'b1; sm_stored_i = 24'h0; sm_computed_i = d;
    @(negedge clk);
    sm_valid_i = 1'b0;
    saw_fetch = sm_fetch_req_o;
    @(negedge clk);
    @(negedge clk);
    check(sm_valid_o && {sm_status_o, sm_idx_o, sm_bit_o, sm_byte_o} == {s, idx, b, by},
          tag, "bounded sector result",
          32'({sm_status_o, sm_idx_o, sm_bit_o, sm_byte_o}), 32'({s, idx, b, by}));
    check(saw_fetch == (s == 2'd1), tag, "bounded fetch request",
          32'(saw_fetch), 32'(s == 2'd1));
  endtask

  initial begin
    fork
      monitor();
      begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
      end
    join_none

    repeat (4) @(negedge clk);
    // R10: outputs quiet in reset
    check(!enc_valid_o && !chk_valid_o && !fetch_req_o, "R10", "reset outputs",
          32'({enc_valid_o, chk_valid_o, fetch_req_o}), 32'd0);
    rst = 1'b0;
    @(negedge clk);

    // R1 / R2: encoder
    enc_case(32'h0000_0000, 24'hFFFFFF, "R2");
    enc_case(32'hF000_F000, 24'hFFFFFF, "R2");
    enc_case(32'h0ABC_0123, 24'h543EDC, "R1");
    enc_case(32'h1234_5678, 24'hDCB987, "R1");

    // R3: clean
    push(24'hFFFFFF, 24'hFFFFFF, "R3");
    idle(4);
    push(24'h5A3C71, 24'h5A3C71, "R3");
    idle(4);

    // R4 / R8: correctable, extremes of byte and bit
    push(24'h123456, 24'h123456 ^ err_pattern(0, 0), "R4");
    idle(4);
    push(24'hFFFFFF, 24'hFFFFFF ^ err_pattern(511, 7), "R8");
    idle(4);
    push(24'h00FF00, 24'h00FF00 ^ err_pattern(200, 3), "R4");
    idle(4);

    // R6: code-only damage
    push(24'hABCDEF, 24'hABCDEF ^ 24'h000001, "R6");
    idle(4);
    push(24'hABCDEF, 24'hABCDEF ^ 24'h001000, "R6");
    idle(4);
    push(24'hABCDEF, 24'hABCDEF ^ 24'h800000, "R6");
    idle(4);

    // R7: uncorrectable
    push(24'h000000, 24'h000003, "R7");
    idle(4);
    push(24'h000000, 24'hFFFFFF, "R7");
    idle(4);
    push(24'h000000, 24'h800001, "R7");
    idle(4);
    drain();

    // R9: back-to-back mixed burst
    push(24'h111111, 24'h111111 ^ err_pattern(77, 5), "R9");
    push(24'h222222, 24'h222222, "R9");
    push(24'h333333, 24'h333333 ^ 24'h000400, "R9");
    push(24'h444444, 24'h444444 ^ err_pattern(1, 6), "R9");
    push(24'h555555, 24'h555555 ^ err_pattern(510, 2), "R9");
    push(24'h666666, 24'h666666 ^ 24'h0F0F0F, "R9");
    push(24'h777777, 24'h777777 ^ err_pattern(300, 1), "R9");
    drain();

    // R5: bounded sector
    small_case(err_pattern(299, 4), "R5");
    small_case(err_pattern(300, 0), "R5");
    small_case(err_pattern(511, 7), "R5");

    idle(4);
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

endmodule